// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit multiply-accumulate register, split into a high word (MACH) and a low word (MACL), and carries out the family of multiply operations that write it. It covers a 32x32 multiply that keeps the low 32 bits, and 16x16 multiplies in signed and unsigned forms. It also covers 32x32 multiplies with a full 64-bit signed or unsigned result, and accumulating multiplies on 32-bit and 16-bit operands. An S input selects saturating accumulation. A surrounding core supplies the two operand values with a request. It reads the register through two word-wide outputs and can overwrite either word through a pair of load strobes.

A request is accepted only in the idle state. The work takes two cycles: one to form the product and one to merge it into the register. A one-cycle done pulse follows. The control is a three-state machine:
- IDLE: accepts a request and any loads.
- MULT: registers the product.
- WRITE: updates the accumulator.

The transitions are IDLE to MULT on a request, MULT to WRITE always, and WRITE to IDLE always. Requests and loads that arrive while the block is busy are dropped.

Top module: `mac_accum_unit`

## Requirements
- R1: After reset, MACH and MACL are zero, and busy and done are low.
- R2: Operation code 0 (32x32 multiply) writes the low 32 bits of the product to MACL and leaves MACH unchanged.
- R3: Operation code 1 multiplies the low 16 bits of each operand, zero-extended. Operation code 2 multiplies them sign-extended. Either writes the 32-bit product to MACL and leaves MACH unchanged.
- R4: Operation code 3 writes the 64-bit unsigned product of the two operands to MACH:MACL. Operation code 4 writes the 64-bit signed product.
- R5: Operation code 5 with S=0 adds the signed 64-bit product to the 64-bit register, wrapping modulo 2^64.
- R6: Operation code 5 with S=1 works as follows. It adds the signed product to the sign-extended low 48 bits of the register. It clamps the sum to the range -2^47 to 2^47-1 and writes it to bits 47:0. Bits 63:48 are kept.
- R7: Operation code 6 with S=0 adds the signed product of the sign-extended low 16-bit operand halves to the register, with that product sign-extended to 64 bits.
- R8: Operation code 6 with S=1 adds the same product to MACL taken as a signed 32-bit value. It clamps the result to the signed 32-bit range in MACL. On overflow it sets MACH bit 0 and otherwise leaves MACH unchanged.
- R9: While idle, ld_hi replaces MACH and ld_lo replaces MACL with ld_data at the next edge. Both may be used in the same cycle.
- R10: A request sampled while idle makes busy high for the next two cycles. The new register value and a single-cycle done pulse appear together after the third edge, and busy is low during that cycle.
- R11: Requests and loads presented while busy have no effect.
- R12: Operation code 7 goes through the same sequence with done but leaves the register unchanged. S has no effect on codes 0 to 4 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 3 | Operation code (see requirements) |
| req_a | input | 32 | First operand |
| req_b | input | 32 | Second operand |
| req_sat | input | 1 | S flag: saturating accumulate |
| ld_hi | input | 1 | Load MACH from ld_data |
| ld_lo | input | 1 | Load MACL from ld_data |
| ld_data | input | 32 | Load value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mach | output | 32 | Accumulator bits 63:32 |
| macl | output | 32 | Accumulator bits 31:0 |

## Verification
When a request is sampled at an edge, busy is due just after that edge and the next one. The result and done are due just after the third edge, and done must be low again one edge later. Loads are due one edge after they are driven. The bench drives every input on the falling edge and samples 1 ns after the rising edge on which each value is due. A sweep over corner operands, preloaded accumulator values near both saturation limits, every operation code and both S values compares each result against arithmetic done in the bench.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [2:0] {
        OP_MUL32  = 3'd0,
        OP_MULU16 = 3'd1,
        OP_MULS16 = 3'd2,
        OP_DMULU  = 3'd3,
        OP_DMULS  = 3'd4,
        OP_MAC32  = 3'd5,
        OP_MAC16  = 3'd6,
        OP_NOP    = 3'd7
    } mac_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MULT  = 2'd1,
        ST_WRITE = 2'd2
    } mac_state_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input  mac_op_e               op,
    input  logic [DATA_W-1:0]     a,
    input  logic [DATA_W-1:0]     b,
    output logic [2*DATA_W-1:0]   prod
);
    localparam int PW = 2 * DATA_W;

    logic signed [PW:0] ax, bx, full;

    always_comb begin
        unique case (op)
            OP_MULU16: begin
                ax = (PW+1)'($signed({1'b0, a[HALF_W-1:0]}));
                bx = (PW+1)'($signed({1'b0, b[HALF_W-1:0]}));
            end
            OP_MULS16, OP_MAC16: begin
                ax = (PW+1)'($signed(a[HALF_W-1:0]));
                bx = (PW+1)'($signed(b[HALF_W-1:0]));
            end
            OP_DMULU: begin
                ax = (PW+1)'($signed({1'b0, a}));
                bx = (PW+1)'($signed({1'b0, b}));
            end
            OP_MUL32, OP_DMULS, OP_MAC32, OP_NOP: begin
                ax = (PW+1)'($signed(a));
                bx = (PW+1)'($signed(b));
            end
        endcase
        full = ax * bx;
        prod = full[PW-1:0];
    end
endmodule

// File: rtl/mac_sat.sv
module mac_sat
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SAT_W  = 48
) (
    input  mac_op_e               op,
    input  logic                  sat,
    input  logic [2*DATA_W-1:0]   prod,
    input  logic [2*DATA_W-1:0]   mac_q,
    output logic [2*DATA_W-1:0]   mac_d
);
    localparam int AW = 2 * DATA_W;
    localparam logic signed [AW-1:0] SAT_MAX = {{(AW-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic signed [AW-1:0] SAT_MIN = {{(AW-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};
    localparam logic [DATA_W-1:0]    W_MAX   = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0]    W_MIN   = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [AW-1:0]   wide_sum;
    logic signed [DATA_W:0] nar_sum;
    logic                   nar_ovf;

    always_comb begin
        wide_sum = AW'($signed(mac_q[SAT_W-1:0])) + $signed(prod);
        nar_sum  = (DATA_W+1)'($signed(mac_q[DATA_W-1:0]))
                 + (DATA_W+1)'($signed(prod[DATA_W-1:0]));
        nar_ovf  = nar_sum[DATA_W] ^ nar_sum[DATA_W-1];
        mac_d    = mac_q;
        unique case (op)
            OP_MUL32, OP_MULU16, OP_MULS16:
                mac_d[DATA_W-1:0] = prod[DATA_W-1:0];
            OP_DMULU, OP_DMULS:
                mac_d = prod;
            OP_MAC32: begin
                if (!sat)
                    mac_d = mac_q + prod;
                else if (wide_sum > SAT_MAX)
                    mac_d[SAT_W-1:0] = SAT_MAX[SAT_W-1:0];
                else if (wide_sum < SAT_MIN)
                    mac_d[SAT_W-1:0] = SAT_MIN[SAT_W-1:0];
                else
                    mac_d[SAT_W-1:0] = wide_sum[SAT_W-1:0];
            end
            OP_MAC16: begin
                if (!sat)
                    mac_d = mac_q + prod;
                else if (nar_ovf) begin
                    mac_d[DATA_W-1:0] = nar_sum[DATA_W] ? W_MIN : W_MAX;
                    mac_d[DATA_W]     = 1'b1;
                end else
                    mac_d[DATA_W-1:0] = nar_sum[DATA_W-1:0];
            end
            OP_NOP: ;
        endcase
    end
endmodule

// File: rtl/mac_accum_unit.sv
module mac_accum_unit
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16,
    parameter int SAT_W  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [DATA_W-1:0] req_a,
    input  logic [DATA_W-1:0] req_b,
    input  logic              req_sat,
    input  logic              ld_hi,
    input  logic              ld_lo,
    input  logic [DATA_W-1:0] ld_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] mach,
    output logic [DATA_W-1:0] macl
);
    localparam int AW = 2 * DATA_W;

    mac_state_e        state_q, state_d;
    mac_op_e           op_q;
    logic [DATA_W-1:0] a_q, b_q;
    logic              sat_q, done_q;
    logic [AW-1:0]     prod_w, prod_q, mac_q, mac_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_MULT;
            ST_MULT:  state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = done_q;
        mach = mac_q[AW-1:DATA_W];
        macl = mac_q[DATA_W-1:0];
    end

    mac_mult #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_mult (
        .op(op_q), .a(a_q), .b(b_q), .prod(prod_w)
    );

    mac_sat #(.DATA_W(DATA_W), .SAT_W(SAT_W)) u_sat (
        .op(op_q), .sat(sat_q), .prod(prod_q), .mac_q(mac_q), .mac_d(mac_nx)
    );

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NOP;
            a_q    <= '0;
            b_q    <= '0;
            sat_q  <= 1'b0;
            prod_q <= '0;
            mac_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q  <= mac_op_e'(req_op);
                        a_q   <= req_a;
                        b_q   <= req_b;
                        sat_q <= req_sat;
                    end
                    if (ld_hi) mac_q[AW-1:DATA_W]  <= ld_data;
                    if (ld_lo) mac_q[DATA_W-1:0]   <= ld_data;
                end
                ST_MULT:  prod_q <= prod_w;
                ST_WRITE: begin
                    mac_q  <= mac_nx;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mac_chk.sv
module mac_chk #(
    parameter int DATA_W = 32,
    parameter int SAT_W  = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic              req_sat,
    input logic              ld_hi,
    input logic              ld_lo,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] mach,
    input logic [DATA_W-1:0] macl
);
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R10
    AST_BUSY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10
    AST_ACCEPT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !ld_hi && !ld_lo) |=> $stable({mach, macl})); // R10
    AST_NARROW_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ($past(req_op, 3) <= 3'd2)) |-> $stable(mach)); // R3
    AST_SAT48_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(req_op, 3) == 3'd5 && $past(req_sat, 3))
        |-> mach[DATA_W-1:SAT_W-DATA_W] == $past(mach[DATA_W-1:SAT_W-DATA_W])); // R6
    AST_NOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(req_op, 3) == 3'd7) |-> $stable({mach, macl})); // R12
endmodule

bind mac_accum_unit mac_chk #(.DATA_W(DATA_W), .SAT_W(SAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_sat(req_sat), .ld_hi(ld_hi), .ld_lo(ld_lo), .busy(busy),
    .done(done), .mach(mach), .macl(macl)
);

// File: tb/tb_mac_accum_unit.sv
`timescale 1ns/100ps
module tb_mac_accum_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [31:0] req_a = '0, req_b = '0, ld_data = '0;
    logic        req_sat = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
    logic        busy, done;
    logic [31:0] mach, macl;

    int n_vec = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mac_accum_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_a(req_a), .req_b(req_b), .req_sat(req_sat), .ld_hi(ld_hi),
        .ld_lo(ld_lo), .ld_data(ld_data), .busy(busy), .done(done),
        .mach(mach), .macl(macl)
    );

    function automatic logic [31:0] opnd(int i);
        case (i)
            0: return 32'h0000_0000;  1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;  3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;  5: return 32'h1234_5678;
            6: return 32'hFFFF_8000;  default: return 32'h0000_7FFF;
        endcase
    endfunction

    function automatic logic [63:0] seed(int i);
        case (i)
            0: return 64'h0000_0000_0000_0000;
            1: return 64'h0000_7FFF_FFFF_FF00;
            2: return 64'hABCD_8000_0000_0100;
            3: return 64'h1234_5678_7FFF_FFF0;
            4: return 64'hFFFF_FFFE_8000_0010;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic string tag(int op, bit s);
        case (op)
            0: return "R2";  1, 2: return "R3";  3, 4: return "R4";
            5: return s ? "R6" : "R5";
            6: return s ? "R8" : "R7";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [63:0] model(int op, logic [31:0] a, logic [31:0] b,
                                          bit s, logic [63:0] m);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ps, acc;
        logic [63:0] u = {32'b0, a} * {32'b0, b};
        logic [31:0] pu = 32'(a[15:0]) * 32'(b[15:0]);
        ps = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        case (op)
            0: return {m[63:32], u[31:0]};
            1: return {m[63:32], pu};
            2: return {m[63:32], ps[31:0]};
            3: return u;
            4: return sa * sb;
            5: begin
                if (!s) return m + (sa * sb);
                acc = longint'($signed(m[47:0])) + sa * sb;
                if (acc > 64'sh0000_7FFF_FFFF_FFFF) acc = 64'sh0000_7FFF_FFFF_FFFF;
                if (acc < -64'sh0000_8000_0000_0000) acc = -64'sh0000_8000_0000_0000;
                return {m[63:48], acc[47:0]};
            end
            6: begin
                if (!s) return m + ps;
                acc = longint'($signed(m[31:0])) + ps;
                if (acc > 64'sd2147483647)  return {m[63:33], 1'b1, 32'h7FFF_FFFF};
                if (acc < -64'sd2147483648) return {m[63:33], 1'b1, 32'h8000_0000};
                return {m[63:32], acc[31:0]};
            end
            default: return m;
        endcase
    endfunction

    task automatic check(bit ok, string t, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", t, act, exp);
        end
    endtask

    task automatic preload(logic [63:0] m);
        @(negedge clk); ld_hi = 1'b1; ld_data = m[63:32];
        @(negedge clk); ld_hi = 1'b0; ld_lo = 1'b1; ld_data = m[31:0];
        @(negedge clk); ld_lo = 1'b0;
    endtask

    // issues a request at the current negedge; returns after edge e2 + 1 ns
    task automatic issue(int op, logic [31:0] a, logic [31:0] b, bit s);
        req_valid = 1'b1; req_op = 3'(op); req_a = a; req_b = b; req_sat = s;
        @(posedge clk);
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] e, m;
        repeat (3) @(posedge clk);
        #1;
        check(mach == 0 && macl == 0 && !busy && !done, "R1",
              {mach, macl}, 64'h0);
        @(negedge clk); rst_n = 1'b1;

        // R9: both words loaded in one cycle, then separately
        @(negedge clk); ld_hi = 1'b1; ld_lo = 1'b1; ld_data = 32'hC0DE_0001;
        @(posedge clk); #1;
        check({mach, macl} == 64'hC0DE_0001_C0DE_0001, "R9",
              {mach, macl}, 64'hC0DE_0001_C0DE_0001);
        @(negedge clk); ld_lo = 1'b0; ld_data = 32'h5555_AAAA;
        @(posedge clk); #1;
        check({mach, macl} == 64'h5555_AAAA_C0DE_0001, "R9",
              {mach, macl}, 64'h5555_AAAA_C0DE_0001);
        @(negedge clk); ld_hi = 1'b0;

        // R10: cycle timing of busy and done
        preload(64'h1);
        req_valid = 1'b1; req_op = 3'd3; req_a = 32'd7; req_b = 32'd9; req_sat = 1'b0;
        @(posedge clk); #1;
        check(busy && !done && {mach, macl} == 64'h1, "R10", {63'b0, busy}, 64'h1);
        @(negedge clk); req_valid = 1'b0;
        @(posedge clk); #1;
        check(busy && !done, "R10", {63'b0, busy}, 64'h1);
        @(posedge clk); #1;
        check(!busy && done && {mach, macl} == 64'd63, "R10", {mach, macl}, 64'd63);
        @(posedge clk); #1;
        check(!busy && !done, "R10", {63'b0, done}, 64'h0);

        // R11: request and loads while busy are dropped
        m = 64'h0102_0304_0506_0708;
        preload(m);
        req_valid = 1'b1; req_op = 3'd0; req_a = 32'h0001_0003; req_b = 32'h0000_0005;
        req_sat = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_op = 3'd4; req_a = 32'hFFFF_FFFF; req_b = 32'h1234;
        ld_hi = 1'b1; ld_lo = 1'b1; ld_data = 32'hDEAD_BEEF;
        @(posedge clk);
        @(posedge clk); #1;
        e = model(0, 32'h0001_0003, 32'h0000_0005, 1'b0, m);
        check(done && {mach, macl} == e, "R11", {mach, macl}, e);
        @(negedge clk); req_valid = 1'b0; ld_hi = 1'b0; ld_lo = 1'b0;
        @(posedge clk); #1;
        check(!busy && !done && {mach, macl} == e, "R11", {mach, macl}, e);

        // sweep: accumulator seed x operand pairs x every op x S
        for (int sd = 0; sd < 6; sd++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int op = 0; op < 8; op++)
                        for (int s = 0; s < 2; s++) begin
                            preload(seed(sd));
                            issue(op, opnd(i), opnd(j), s[0]);
                            e = model(op, opnd(i), opnd(j), s[0], seed(sd));
                            check(done && {mach, macl} == e, tag(op, s[0]),
                                  {mach, macl}, e);
                        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule